// File: doc/BRIEF.md
# D-PHY Test-Port Write Sequencer

This block owns the serial test-control port of a D-PHY. Upstream logic hands it commands one at a time through a valid/ready handshake. The commands are register writes carrying an address and a data byte, a port clear, a staged power-up with a lock poll, and a power-off. Software decides the values to load and the order they come in, for example clock-lane timings, then each data lane, then the PLL bytes. The block turns each command into the exact pin choreography the PHY expects and executes commands strictly in the order they are accepted.

A register write is a two-phase latch on the port. First the address byte is presented with the address-select line high and given its own strobe pulse. Then the data byte is presented with address-select low and given a second strobe pulse. Each phase (setup, strobe high, hold) lasts a number of system clocks taken from an input at accept time, so setup and hold at the PHY can be met at any system clock rate. The power-up command raises the clock enable, the power-on control and the reset release one at a time, with a fixed wait after each step. It then samples the PHY status until lock or clock-lane stop state is seen, or until a bounded number of samples has been taken. If the samples run out, it raises a sticky not-ready flag.

Top module: `dphy_tport_seq`

## Requirements
- R1: After a synchronous reset, all test-port and power outputs are low, `busy` and `not_ready` are low and `cmd_ready` is high.
- R2: A write command (op code 0) drives `tp_addr_sel`=1 with `tp_bus`=address for three phases (strobe low, strobe high, strobe low). It then drives `tp_addr_sel`=0 with `tp_bus`=data for three more such phases. Each phase lasts L cycles, where L is `phase_len` sampled at accept and a value of 0 counts as 1. The first phase is visible in the cycle after the accepting edge.
- R3: A clear command (op code 1) drops all three power controls to 0 at accept. It then drives `tp_clear` low for L cycles, high for L cycles and low for L cycles, with `tp_strobe` held low.
- R4: A power-up command (op code 2) sets the power controls {`phy_out_of_reset`,`phy_power_on`,`phy_clk_en`} to 001 for STEP_CYC cycles, then 011 for STEP_CYC cycles, then 111. After that it waits a further STEP_CYC cycles before the first status sample.
- R5: During polling, `phy_stat` is sampled once every POLL_WAIT+1 cycles. Bit 0 (PLL lock) or bit 2 (clock-lane stop state) set ends the command with `not_ready` low, and bit 1 is ignored.
- R6: When POLL_MAX samples in a row find neither status bit set, the command ends and `not_ready` goes high in the same cycle that `busy` falls. It stays high through other commands until the next power-up command is accepted, which clears it.
- R7: `busy` is high from the accepting edge until the command ends, and `cmd_ready` is its inverse. A command offered while busy is not accepted and has no effect on any output.
- R8: A power-off command (op code 3) drops all three power controls to 0. It holds `busy` for exactly one cycle and causes no test-port activity.
- R9: Between commands the test port idles with `tp_clear`, `tp_strobe`, `tp_addr_sel` low and `tp_bus` zero. The power controls hold their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted on this edge when high with cmd_valid |
| cmd_op | input | 2 | 0 write, 1 clear, 2 power-up, 3 power-off |
| cmd_addr | input | 8 | Test register address for a write |
| cmd_data | input | 8 | Data byte for a write |
| phase_len | input | PH_W | Cycles per port phase, sampled at accept (0 acts as 1) |
| busy | output | 1 | A command is executing |
| not_ready | output | 1 | Sticky: last power-up timed out without lock or stop state |
| phy_stat | input | 3 | PHY status; bit 0 lock, bit 2 clock-lane stop state |
| tp_clear | output | 1 | Test-port clear |
| tp_strobe | output | 1 | Test-port clock |
| tp_addr_sel | output | 1 | High while the address byte is presented |
| tp_bus | output | 8 | Test-port data in |
| phy_clk_en | output | 1 | PHY clock enable |
| phy_power_on | output | 1 | PHY out of shutdown |
| phy_out_of_reset | output | 1 | PHY reset released |

## Verification
The bench builds the block with PH_W=4, STEP_CYC=4, POLL_WAIT=2 and POLL_MAX=5. These values shrink a full power-up to a few dozen cycles, so a timeout and a lock found partway through polling both fit in a short run. A 4-bit phase length lets the bench use the zero length, a length of one and longer stretched phases in the same run. A behavioural model built from queues of timed output segments predicts every output on every cycle, including commands held back while the block is busy.

// File: rtl/dphy_tport_pkg.sv
// Shared types for the D-PHY test-port sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package dphy_tport_pkg;

    // Command codes carried on cmd_op.
    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_CLEAR  = 2'd1,
        OP_PWRUP  = 2'd2,
        OP_PWROFF = 2'd3
    } tport_op_e;

    // Sequencer states; each names one visible phase on the pins.
    typedef enum logic [3:0] {
        S_IDLE,
        S_A_SET,
        S_A_HI,
        S_A_HLD,
        S_D_SET,
        S_D_HI,
        S_D_HLD,
        S_C_LO0,
        S_C_HI,
        S_C_LO1,
        S_P_CLK,
        S_P_SHD,
        S_P_RST,
        S_P_SMP,
        S_P_WAIT,
        S_OFF
    } tport_state_e;

endpackage

// File: rtl/dphy_tport_timer.sv
// Phase timer: a loadable down-counter that flags the last cycle of a phase.
// Assumes: the owner pulses load on every phase entry with (length - 1).
module dphy_tport_timer #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    // Count down the current phase; reload on phase entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/dphy_tport_poll.sv
// Poll bookkeeping: counts failed status samples and owns the sticky not-ready flag.
// Assumes: clr is pulsed when a power-up command is accepted; step and timeout
// are mutually exclusive single-cycle pulses from the sampling state.
module dphy_tport_poll #(
    parameter int POLL_MAX = 100,
    localparam int PC_W    = $clog2(POLL_MAX + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    input  logic timeout,
    output logic last,
    output logic not_ready
);

    logic [PC_W-1:0] cnt;

    // Track how many samples have failed in this power-up.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + PC_W'(1);
        end
    end

    // Raise not-ready on timeout; only a new power-up lowers it.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            not_ready <= 1'b0;
        end else if (timeout) begin
            not_ready <= 1'b1;
        end
    end

    assign last = (cnt == PC_W'(POLL_MAX - 1));

    // R6: the sample budget can never be exceeded.
    p_poll_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < PC_W'(POLL_MAX));

    // R6: the flag only rises after the final allowed sample.
    p_flag_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(not_ready) |-> $past(last));

endmodule

// File: rtl/dphy_tport_seq.sv
// D-PHY test-port sequencer top.
// Accepts one command at a time (write, clear, power-up, power-off) and plays
// it out on the test-port pins and PHY power controls. Phase lengths come from
// phase_len (sampled at accept), the power-step wait from STEP_CYC, and the
// poll spacing and budget from POLL_WAIT and POLL_MAX.
// Assumes: phy_stat is already synchronous to clk; POLL_WAIT >= 1, STEP_CYC >= 1.
module dphy_tport_seq #(
    parameter int PH_W      = 8,
    parameter int STEP_CYC  = 100,
    parameter int POLL_WAIT = 99,
    parameter int POLL_MAX  = 100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    output logic            cmd_ready,
    input  logic [1:0]      cmd_op,
    input  logic [7:0]      cmd_addr,
    input  logic [7:0]      cmd_data,
    input  logic [PH_W-1:0] phase_len,
    output logic            busy,
    output logic            not_ready,
    input  logic [2:0]      phy_stat,
    output logic            tp_clear,
    output logic            tp_strobe,
    output logic            tp_addr_sel,
    output logic [7:0]      tp_bus,
    output logic            phy_clk_en,
    output logic            phy_power_on,
    output logic            phy_out_of_reset
);
    import dphy_tport_pkg::*;

    localparam int PH_MAX = (1 << PH_W);
    localparam int M1     = (PH_MAX > STEP_CYC) ? PH_MAX : STEP_CYC;
    localparam int M2     = (M1 > POLL_WAIT) ? M1 : POLL_WAIT;
    localparam int CNT_W  = $clog2(M2) + 1;

    tport_state_e     state, state_n;
    logic [7:0]       addr_q, data_q;
    logic [CNT_W-1:0] lenm1_q, load_val;
    logic             accept, expired, stat_ok;
    logic             poll_last, poll_step, poll_to;
    logic [2:0]       pwr_q;   // {out_of_reset, power_on, clk_en}

    assign cmd_ready = (state == S_IDLE);
    assign busy      = (state != S_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign stat_ok   = |(phy_stat & 3'b101);

    // Latch the command fields and phase length at accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            data_q  <= '0;
            lenm1_q <= '0;
        end else if (accept) begin
            addr_q  <= cmd_addr;
            data_q  <= cmd_data;
            lenm1_q <= (phase_len == '0) ? '0 : CNT_W'(phase_len) - CNT_W'(1);
        end
    end

    // Choose the next phase from the current one, the timer and the status.
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE: begin
                if (cmd_valid) begin
                    unique case (tport_op_e'(cmd_op))
                        OP_WRITE:  state_n = S_A_SET;
                        OP_CLEAR:  state_n = S_C_LO0;
                        OP_PWRUP:  state_n = S_P_CLK;
                        OP_PWROFF: state_n = S_OFF;
                    endcase
                end
            end
            S_A_SET:  if (expired) state_n = S_A_HI;
            S_A_HI:   if (expired) state_n = S_A_HLD;
            S_A_HLD:  if (expired) state_n = S_D_SET;
            S_D_SET:  if (expired) state_n = S_D_HI;
            S_D_HI:   if (expired) state_n = S_D_HLD;
            S_D_HLD:  if (expired) state_n = S_IDLE;
            S_C_LO0:  if (expired) state_n = S_C_HI;
            S_C_HI:   if (expired) state_n = S_C_LO1;
            S_C_LO1:  if (expired) state_n = S_IDLE;
            S_P_CLK:  if (expired) state_n = S_P_SHD;
            S_P_SHD:  if (expired) state_n = S_P_RST;
            S_P_RST:  if (expired) state_n = S_P_SMP;
            S_P_SMP:  state_n = (stat_ok || poll_last) ? S_IDLE : S_P_WAIT;
            S_P_WAIT: if (expired) state_n = S_P_SMP;
            S_OFF:    state_n = S_IDLE;
        endcase
    end

    // Pick the length of the phase being entered.
    always_comb begin
        unique case (state_n)
            S_P_CLK, S_P_SHD, S_P_RST: load_val = CNT_W'(STEP_CYC - 1);
            S_P_WAIT:                  load_val = CNT_W'(POLL_WAIT - 1);
            S_P_SMP, S_OFF, S_IDLE:    load_val = '0;
            default:
                load_val = accept ? ((phase_len == '0) ? '0
                                     : CNT_W'(phase_len) - CNT_W'(1))
                                  : lenm1_q;
        endcase
    end

    // Advance the sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    dphy_tport_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_n != state),
        .load_val (load_val),
        .expired  (expired)
    );

    assign poll_step = (state == S_P_SMP) && !stat_ok && !poll_last;
    assign poll_to   = (state == S_P_SMP) && !stat_ok && poll_last;

    dphy_tport_poll #(.POLL_MAX(POLL_MAX)) u_poll (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (accept && (cmd_op == OP_PWRUP)),
        .step      (poll_step),
        .timeout   (poll_to),
        .last      (poll_last),
        .not_ready (not_ready)
    );

    // Step the PHY power controls: set at accept, add one control per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_q <= 3'b000;
        end else if (accept) begin
            pwr_q <= (cmd_op == OP_PWRUP) ? 3'b001 : (cmd_op == OP_WRITE) ? pwr_q : 3'b000;
        end else if (state == S_P_CLK && expired) begin
            pwr_q <= 3'b011;
        end else if (state == S_P_SHD && expired) begin
            pwr_q <= 3'b111;
        end
    end

    assign phy_clk_en       = pwr_q[0];
    assign phy_power_on     = pwr_q[1];
    assign phy_out_of_reset = pwr_q[2];

    // Decode the test-port pins from the current phase.
    always_comb begin
        tp_clear    = (state == S_C_HI);
        tp_strobe   = (state == S_A_HI) || (state == S_D_HI);
        tp_addr_sel = (state == S_A_SET) || (state == S_A_HI) || (state == S_A_HLD);
        if (tp_addr_sel)
            tp_bus = addr_q;
        else if ((state == S_D_SET) || (state == S_D_HI) || (state == S_D_HLD))
            tp_bus = data_q;
        else
            tp_bus = 8'h00;
    end

    // R2: the bus and select are steady while the strobe is high.
    p_strobe_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tp_strobe |-> ($stable(tp_bus) && $stable(tp_addr_sel)));

    // R3: clear and strobe never overlap, and clear only pulses with reset held.
    p_clear_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tp_clear |-> (!tp_strobe && !phy_out_of_reset));

    // R4: reset release implies the two earlier steps are in place.
    p_pwr_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        phy_out_of_reset |-> (phy_power_on && phy_clk_en));

    // R4: power-on only rises once the clock enable was already up.
    p_pwr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_power_on) |-> $past(phy_clk_en));

    // R6: the not-ready flag rises exactly when a command ends.
    p_flag_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(not_ready) |-> $fell(busy));

    // R7: an accepted command makes the block busy on the next cycle.
    p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> busy);

endmodule

// File: tb/dphy_tport_seq_tb.sv
// Bench: behavioural segment-queue model, compared with every output each cycle.
module dphy_tport_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int PH_W       = 4;
    localparam int STEP_CYC   = 4;
    localparam int POLL_WAIT  = 2;
    localparam int POLL_MAX   = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic            cmd_ready;
    logic [1:0]      cmd_op = '0;
    logic [7:0]      cmd_addr = '0, cmd_data = '0;
    logic [PH_W-1:0] phase_len = '0;
    logic            busy, not_ready;
    logic [2:0]      phy_stat = '0;
    logic            tp_clear, tp_strobe, tp_addr_sel;
    logic [7:0]      tp_bus;
    logic            phy_clk_en, phy_power_on, phy_out_of_reset;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dphy_tport_seq #(
        .PH_W(PH_W), .STEP_CYC(STEP_CYC), .POLL_WAIT(POLL_WAIT), .POLL_MAX(POLL_MAX)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .phase_len(phase_len), .busy(busy), .not_ready(not_ready),
        .phy_stat(phy_stat), .tp_clear(tp_clear), .tp_strobe(tp_strobe),
        .tp_addr_sel(tp_addr_sel), .tp_bus(tp_bus), .phy_clk_en(phy_clk_en),
        .phy_power_on(phy_power_on), .phy_out_of_reset(phy_out_of_reset)
    );

    // Model: queue of timed segments; tag codes name the requirement.
    int  q_val[$], q_len[$], q_pw[$], q_tag[$];
    bit  q_lst[$];
    bit  in_poll = 0, m_nr = 0, seen_rst = 0, finished = 0;
    int  m_pw = 0, wt = 0, polls = 0, seg_l = 0;
    bit  was_busy;
    int  vectors = 0, miscompares = 0, cyc = 0;

    function automatic int mk(input bit clr, input bit stb, input bit sel, input int bus);
        return (int'(clr) << 10) | (int'(stb) << 9) | (int'(sel) << 8) | (bus & 8'hff);
    endfunction

    function automatic string tag_s(input int t);
        case (t)
            1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
            5: return "R5"; 6: return "R6"; 7: return "R7"; 8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic push(input int v, input int len, input int pw, input int tg, input bit lst);
        q_val.push_back(v); q_len.push_back(len); q_pw.push_back(pw);
        q_tag.push_back(tg); q_lst.push_back(lst);
    endtask

    // Advance the model on each rising edge, reading only bench-driven inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            q_val.delete(); q_len.delete(); q_pw.delete(); q_tag.delete(); q_lst.delete();
            in_poll = 0; m_nr = 0; m_pw = 0; seen_rst = 1;
        end else begin
            was_busy = (q_len.size() != 0) || in_poll;
            if (q_len.size() != 0) begin
                q_len[0] = q_len[0] - 1;
                if (q_len[0] == 0) begin
                    if (q_lst[0]) begin in_poll = 1; wt = 0; polls = 0; end
                    void'(q_val.pop_front()); void'(q_len.pop_front());
                    void'(q_pw.pop_front()); void'(q_tag.pop_front()); void'(q_lst.pop_front());
                end
            end else if (in_poll) begin
                if (wt > 0) wt--;
                else if (phy_stat[0] || phy_stat[2]) in_poll = 0;
                else if (polls == POLL_MAX - 1) begin m_nr = 1; in_poll = 0; end
                else begin polls++; wt = POLL_WAIT; end
            end
            if (!was_busy && cmd_valid) begin
                seg_l = (phase_len == 0) ? 1 : int'(phase_len);
                case (cmd_op)
                    2'd0: begin
                        push(mk(0,0,1,cmd_addr), seg_l, -1, 2, 0);
                        push(mk(0,1,1,cmd_addr), seg_l, -1, 2, 0);
                        push(mk(0,0,1,cmd_addr), seg_l, -1, 2, 0);
                        push(mk(0,0,0,cmd_data), seg_l, -1, 2, 0);
                        push(mk(0,1,0,cmd_data), seg_l, -1, 2, 0);
                        push(mk(0,0,0,cmd_data), seg_l, -1, 2, 0);
                    end
                    2'd1: begin
                        push(mk(0,0,0,0), seg_l, 0, 3, 0);
                        push(mk(1,0,0,0), seg_l, 0, 3, 0);
                        push(mk(0,0,0,0), seg_l, 0, 3, 0);
                    end
                    2'd2: begin
                        m_nr = 0;
                        push(0, STEP_CYC, 1, 4, 0);
                        push(0, STEP_CYC, 3, 4, 0);
                        push(0, STEP_CYC, 7, 4, 1);
                    end
                    default: push(0, 1, 0, 8, 0);
                endcase
            end
            if (q_pw.size() != 0 && q_pw[0] >= 0) m_pw = q_pw[0];
        end
    end

    // Compare all outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (seen_rst && !finished) begin
            int  e_port, a_port, tg, a_pw;
            bit  e_busy;
            e_busy = (q_len.size() != 0) || in_poll;
            e_port = (q_val.size() != 0) ? q_val[0] : 0;
            a_port = mk(tp_clear, tp_strobe, tp_addr_sel, tp_bus);
            a_pw   = {phy_out_of_reset, phy_power_on, phy_clk_en};
            tg = !rst_n ? 1 : (q_tag.size() != 0) ? q_tag[0] : in_poll ? 5 : 9;
            vectors++;
            if (busy !== e_busy || cmd_ready !== !e_busy) begin
                miscompares++;
                $display("FAIL R7 busy/ready act=%0b/%0b exp=%0b/%0b t=%0t",
                         busy, cmd_ready, e_busy, !e_busy, $time);
            end else if (not_ready !== m_nr) begin
                miscompares++;
                $display("FAIL R6 not_ready act=%0b exp=%0b t=%0t", not_ready, m_nr, $time);
            end else if (a_port !== e_port || a_pw !== m_pw) begin
                miscompares++;
                $display("FAIL %s port/pwr act=%03h/%0d exp=%03h/%0d t=%0t",
                         tag_s(tg), a_port, a_pw, e_port, m_pw, $time);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL R7 watchdog act=%0d exp<=20000 cycles", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic send(input int op, input int a, input int d, input int len);
        @(negedge clk);
        cmd_valid = 1; cmd_op = 2'(op); cmd_addr = 8'(a); cmd_data = 8'(d);
        phase_len = PH_W'(len);
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);          // R1: reset state compared here
        rst_n = 1;
        repeat (3) @(negedge clk);
        send(1, 0, 0, 2);                   // R3 clear, L=2
        // R2 clock-lane style writes, queued back to back (R7 backpressure)
        send(0, 8'h10, 8'h05, 1);
        send(0, 8'h11, 8'h0a, 3);
        send(0, 8'h12, 8'h1f, 0);           // R2: zero length acts as one
        send(0, 8'h13, 8'h06, 2);
        wait_idle();                        // R9 idle between commands
        // R7: offer a command while busy, withdraw before ready
        send(0, 8'h20, 8'ha5, 4);
        @(negedge clk); cmd_valid = 1; cmd_op = 2'd3;
        repeat (5) @(negedge clk); cmd_valid = 0;
        wait_idle();
        // R4/R5: lock seen on the very first sample
        phy_stat = 3'b001;
        send(2, 0, 0, 1);
        wait_idle();
        // R6: only bit 1 set, so polling times out
        phy_stat = 3'b010;
        send(2, 0, 0, 1);
        wait_idle();
        phy_stat = 3'b000;
        send(0, 8'h40, 8'h3c, 1);           // R6: flag persists across writes
        send(3, 0, 0, 1);                   // R8 power-off
        wait_idle();
        // R5: stop-state bit arrives partway through polling, clears R6 flag
        send(2, 0, 0, 1);
        repeat (14) @(negedge clk);
        phy_stat = 3'b100;
        wait_idle();
        phy_stat = 3'b000;
        send(1, 0, 0, 1);                   // R3 clear after power-up
        wait_idle();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule